// File: doc/BRIEF.md
# Multi-Channel Programmable Down-Counting Timer

This block is a register-mapped timer with a parameterized number of independent down-counting channels. Each channel has its own control word, a reload (interval) value and a live count. Tick-enable inputs from several sources drive the counting. A channel picks one source, divides its ticks by a power of two and decrements once per divided tick. When a channel reaches zero it posts a pending bit in a shared status register. The channel then either reloads its interval and keeps going, or stops at zero and drops its own enable bit.

Software reaches the block over a plain synchronous bus made of address, write enable, write data and combinational read data. A shared mask register gates the pending bits onto one interrupt line. A reload command copies the interval into the counter, and its bit stays readable as one until that copy has been made, so a driver can poll it. A channel given an interval of all-ones and left running works as a timestamp: its count subtracted from all-ones rises by one per divided tick.

Top module: `multi_timer`

## Requirements
- R1: Register offsets: mask at 0x00, status at 0x04, and for channel n the control word at 0x10*n+0x10, the interval at 0x10*n+0x14 and the count at 0x10*n+0x18. Any other offset reads zero. Bit n of mask and of status belongs to channel n.
- R2: After reset every register reads zero and irq_o is low.
- R3: While control bit 0 (run) is set, the count drops by one on each divided tick. While run is clear, the count holds.
- R4: A control write with bit 1 set requests a reload. Bit 1 reads as one in the cycle after the write. The interval is in the counter and bit 1 reads zero one cycle later. This works whether run is set or clear.
- R5: Control bits 3:2 pick which tick_i bit the channel uses. Bits 6:4 hold k, and the channel produces one divided tick for every 2^k selected ticks, counted from the last reload or the last time run was clear. With k=0 every tick counts. Ticks on sources that are not selected have no effect.
- R6: With bit 7 clear (periodic), a divided tick that finds the count at zero sets the status bit and loads the interval. An interval of N therefore gives a period of N+1 divided ticks.
- R7: With bit 7 set (one-shot), a divided tick that finds the count at zero sets the status bit and clears run. The count then stays at zero.
- R8: Writing a one to a status bit clears it. Writing a zero leaves it unchanged. A new expiry in the same cycle wins over the clear.
- R9: irq_o is high exactly when some channel has both its status bit and its mask bit set.
- R10: A write to the count register loads the written value directly.
- R11: The control word reads back bits 7:0 as they are held. Bits 31:8 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data, combinational from addr_i |
| tick_i | input | 4 | Tick-enable sources, one per select code |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench reads the reload bit in the cycle right after the request and again one cycle later. A design that completes the reload too early, or never clears the bit, shows a wrong value in one of the two reads. Random runs pick a source, a divider and a short interval, place noise on the other sources and compare the count with N minus (pulses mod N+1). This catches an off-by-one period, a divider that uses the wrong power, and counting on a source that was not selected. A one-shot run ticks past the expiry. A design that reloads, or that leaves run set, then shows a nonzero count or a wrong control word. Status writes of zero and of one are checked against irq_o under both mask settings.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned PSC_W  = 3;
  localparam int unsigned NUM_SRC = 1 << SRC_W;
  localparam int unsigned CTRL_W = 8;

  // bit order is the software-visible layout
  typedef struct packed {
    logic             one_shot;  // 7
    logic [PSC_W-1:0] psc;       // 6:4
    logic [SRC_W-1:0] src;       // 3:2
    logic             reload;    // 1
    logic             run;       // 0
  } ctrl_t;

  localparam logic [3:0] SUB_CTRL = 4'h0;
  localparam logic [3:0] SUB_INTV = 4'h4;
  localparam logic [3:0] SUB_CNT  = 4'h8;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] mask;

  assign mask    = (DIV_W'(1) << sel_i) - DIV_W'(1);
  assign pulse_o = tick_i && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= '0;
    else if (clr_i)   pcnt_q <= '0;
    else if (tick_i)  pcnt_q <= pcnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               intv_we_i,
  input  logic               cnt_we_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_SRC-1:0] tick_i,
  output ctrl_t              ctrl_o,
  output logic [CNT_W-1:0]   intv_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               expire_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] intv_q, cnt_q;
  logic             src_tick, pulse, at_zero;

  assign src_tick = tick_i[ctrl_q.src] && ctrl_q.run;
  assign at_zero  = (cnt_q == '0);

  timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!ctrl_q.run || ctrl_q.reload),
    .tick_i  (src_tick),
    .sel_i   (ctrl_q.psc),
    .pulse_o (pulse)
  );

  assign expire_o = pulse && at_zero && !ctrl_q.reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end else begin
      if (ctrl_q.reload)                   ctrl_q.reload <= 1'b0;
      if (expire_o && ctrl_q.one_shot)     ctrl_q.run    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        intv_q <= '0;
    else if (intv_we_i) intv_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_we_i)       cnt_q <= wdata_i;
    else if (ctrl_q.reload)  cnt_q <= intv_q;
    else if (pulse) begin
      if (!at_zero)              cnt_q <= cnt_q - CNT_W'(1);
      else if (!ctrl_q.one_shot) cnt_q <= intv_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;

  assert_reload_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.reload && !ctrl_we_i |=> !ctrl_q.reload);
  assert_reload_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.reload && !cnt_we_i |=> cnt_q == $past(intv_q));
  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse && !at_zero && !ctrl_q.reload && !cnt_we_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_hold_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run && !ctrl_q.reload && !cnt_we_i |=> $stable(cnt_q));
  assert_periodic_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && !ctrl_q.one_shot && !cnt_we_i |=> cnt_q == $past(intv_q));
  assert_one_shot_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && ctrl_q.one_shot && !ctrl_we_i && !cnt_we_i |=> !ctrl_q.run && cnt_q == '0);
endmodule

// File: rtl/multi_timer.sv
module multi_timer
  import timer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [3:0]        tick_i,
  output logic              irq_o
);
  localparam int unsigned BLK_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STS  = ADDR_W'(8'h04);

  logic [NUM_CH-1:0] mask_q, sts_q, expire;
  ctrl_t             ch_ctrl [NUM_CH];
  logic [CNT_W-1:0]  ch_intv [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
  logic              sts_we;

  assign sts_we = we_i && (addr_i == OFF_STS);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = (addr_i[ADDR_W-1:4] == BLK_W'(i + 1));

    timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (we_i && hit && addr_i[3:0] == SUB_CTRL),
      .intv_we_i (we_i && hit && addr_i[3:0] == SUB_INTV),
      .cnt_we_i  (we_i && hit && addr_i[3:0] == SUB_CNT),
      .wdata_i   (wdata_i),
      .tick_i    (tick_i[NUM_SRC-1:0]),
      .ctrl_o    (ch_ctrl[i]),
      .intv_o    (ch_intv[i]),
      .cnt_o     (ch_cnt[i]),
      .expire_o  (expire[i])
    );

    // expiry beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     sts_q[i] <= 1'b0;
      else if (expire[i])              sts_q[i] <= 1'b1;
      else if (sts_we && wdata_i[i])   sts_q[i] <= 1'b0;
    end

    assert_sts_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[i] |=> sts_q[i]);
    assert_sts_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sts_q[i] && !(sts_we && wdata_i[i]) |=> sts_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (we_i && addr_i == OFF_MASK)  mask_q <= wdata_i[NUM_CH-1:0];
  end

  assign irq_o = |(sts_q & mask_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_MASK) rdata_o = CNT_W'(mask_q);
    if (addr_i == OFF_STS)  rdata_o = CNT_W'(sts_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i[ADDR_W-1:4] == BLK_W'(i + 1)) begin
        case (addr_i[3:0])
          SUB_CTRL: rdata_o = CNT_W'(ch_ctrl[i]);
          SUB_INTV: rdata_o = ch_intv[i];
          SUB_CNT:  rdata_o = ch_cnt[i];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  assert_irq_needs_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/multi_timer_tb_top.sv
module multi_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  tick = '0;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  multi_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  function automatic logic [31:0] ctrl_off(int ch); return 8'h10 + 8'h10 * ch; endfunction
  function automatic logic [31:0] exp_cnt(logic [31:0] n, int p);
    return n - 32'(p % (n + 1));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdr(logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
    @(negedge clk);
  endtask

  task automatic pulse_src(int src, int n, bit noise);
    for (int k = 0; k < n; k++) begin
      tick = 4'(1 << src);
      if (noise) tick = tick | (4'($urandom) & ~4'(1 << src));
      @(negedge clk);
      tick = '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rdr(8'h00, rd); chk(rd == 0, "R2 mask", rd, 0);
    rdr(8'h04, rd); chk(rd == 0, "R2 status", rd, 0);
    rdr(8'h10, rd); chk(rd == 0, "R2 ctrl0", rd, 0);
    rdr(8'h28, rd); chk(rd == 0, "R2 cnt1", rd, 0);
    chk(irq == 0, "R2 irq", 32'(irq), 0);

    // R11 control readback, R1 offsets
    wr(8'h20, 32'hFFFF_FFFC);
    rdr(8'h20, rd); chk(rd == 32'hFC, "R11 ctrl readback", rd, 32'hFC);
    wr(8'h20, 0);
    wr(8'h24, 32'h55);
    rdr(8'h24, rd); chk(rd == 32'h55, "R1 intv1", rd, 32'h55);
    rdr(8'h14, rd); chk(rd == 0, "R1 intv0 untouched", rd, 0);
    rdr(8'h08, rd); chk(rd == 0, "R1 hole", rd, 0);

    // R10 direct count write
    wr(8'h18, 32'd5);
    rdr(8'h18, rd); chk(rd == 5, "R10 count write", rd, 5);

    // R4 reload while stopped, R7 one-shot
    wr(8'h14, 32'd2);
    wr(8'h10, 32'h82);
    rdr(8'h10, rd); chk(rd[1] == 1'b1, "R4 reload pending", rd, 32'h82);
    rdr(8'h10, rd); chk(rd == 32'h80, "R4 reload done", rd, 32'h80);
    rdr(8'h18, rd); chk(rd == 2, "R4 count loaded", rd, 2);
    wr(8'h10, 32'h81);
    pulse_src(0, 3, 1'b1);
    rdr(8'h10, rd); chk(rd == 32'h80, "R7 run cleared", rd, 32'h80);
    rdr(8'h04, rd); chk(rd[0] == 1'b1, "R7 status set", rd, 1);
    pulse_src(0, 4, 1'b0);
    rdr(8'h18, rd); chk(rd == 0, "R7 holds zero", rd, 0);

    // R9 mask gating, R8 W1C
    chk(irq == 0, "R9 masked", 32'(irq), 0);
    wr(8'h00, 32'h1);
    #1 chk(irq == 1, "R9 unmasked", 32'(irq), 1);
    wr(8'h04, 32'h0);
    rdr(8'h04, rd); chk(rd[0] == 1'b1, "R8 zero write", rd, 1);
    wr(8'h04, 32'h1);
    rdr(8'h04, rd); chk(rd == 0, "R8 clear", rd, 0);
    chk(irq == 0, "R9 after clear", 32'(irq), 0);

    // R5 divider and source select with noise
    wr(8'h24, 32'd10);
    wr(8'h20, 32'h2E);           // psc 2, src 3, reload
    rdr(8'h20, rd);
    wr(8'h20, 32'h2D);
    pulse_src(3, 7, 1'b1);
    rdr(8'h28, rd); chk(rd == 9, "R5 div by 4", rd, 9);
    wr(8'h20, 32'h2C);
    pulse_src(3, 8, 1'b0);
    rdr(8'h28, rd); chk(rd == 9, "R3 stopped hold", rd, 9);

    // R3 timestamp use
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h20, 32'h02);
    rdr(8'h20, rd);
    wr(8'h20, 32'h01);
    pulse_src(0, 5, 1'b0);
    rdr(8'h28, rd); chk(~rd == 5, "R3 timestamp", ~rd, 5);
    wr(8'h20, 0);

    // R6 random periodic runs
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom_range(0, 1);
      int src = $urandom_range(0, 3);
      int psc = $urandom_range(0, 2);
      int t = $urandom_range(0, 40);
      logic [31:0] n = 32'($urandom_range(0, 7));
      logic [31:0] base = {24'h0, 1'b0, 3'(psc), 2'(src), 2'b00};
      int p = t >> psc;
      wr(8'h04, 32'h3);
      wr(8'(ctrl_off(ch) + 4), n);
      wr(8'(ctrl_off(ch)), base | 32'h2);
      rdr(8'(ctrl_off(ch)), rd);
      wr(8'(ctrl_off(ch)), base | 32'h1);
      pulse_src(src, t, 1'b1);
      rdr(8'(ctrl_off(ch) + 8), rd);
      chk(rd == exp_cnt(n, p), "R6 periodic count", rd, exp_cnt(n, p));
      rdr(8'h04, rd);
      chk(rd[ch] == (p >= int'(n) + 1), "R6 periodic status", 32'(rd[ch]), 32'(p >= int'(n) + 1));
      wr(8'(ctrl_off(ch)), 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule